// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This unit carries out a single word-sized compare-and-swap for a processor pipeline. It works against an on-block single-port word memory. The pipeline supplies the instruction word, the contents of the base address register and of its companion pointer register, and the two halves of an even/odd data register pair. The even half is the swap value and the odd half is the compare value. The unit reads the addressed word and compares it with the compare value. It writes the swap value back on a match and writes the unchanged word back otherwise. It always returns the old word for the even destination register.

The unit decodes three encodings, each with its own addressing mode. In base-plus-offset mode the address is the base plus a sign-extended 10-bit offset. In the bit-reverse and circular modes the address is the base plus the low half of the pointer register. For these two modes, the pointer update is handed to a separate address-update unit through a one-cycle request issued alongside the result. Other requesters share the memory through a secondary port. That port is refused for the whole read-compare-write window, so the sequence is atomic.

Top module: `cas_unit`

## Requirements
- R1: During and after synchronous reset, `busy`, `done`, `illegal`, `rd_we`, `upd_en` and `mem_lock` are low.
- R2: The unit accepts three encodings, using primary opcode bits [7:0] and secondary opcode bits [27:22]: 0x49/0x23 selects base-plus-offset, 0x69/0x03 selects bit-reverse and 0x69/0x13 selects circular. Any other pair produces `done` with `illegal` high, `rd_we` low and no memory access: `mem_lock` stays low and memory is unchanged.
- R3: In base-plus-offset mode the byte address is `base_addr` plus the sign-extension of the 10-bit offset. Offset bits [9:6] come from instruction bits [31:28] and offset bits [5:0] come from bits [21:16]. The word used is byte address bits [AW+1:2].
- R4: In bit-reverse and circular modes the byte address is `base_addr` plus the zero-extended `ptr_ctl[15:0]`, and the word used is byte address bits [AW+1:2].
- R5: When the stored word equals `cmp_val`, the word becomes `swap_val` and `swap_hit` is high with `done`.
- R6: When the stored word differs from `cmp_val`, the same unchanged word is written back, the word keeps its value, `swap_hit` is low, and the timing is identical to the match case.
- R7: With `done`, a legal operation raises `rd_we` and presents the old word on `rd_data`. `rd_idx` carries the data register field, instruction bits [11:8].
- R8: If `start` is sampled high while idle, `busy` rises on the next cycle. A legal operation raises `done` for one cycle, three cycles after the start cycle. An illegal one raises `done` in the cycle right after the start cycle. `start` is ignored while `busy` is high.
- R9: `mem_lock` is high for exactly the three cycles from the memory read to the memory write. `ext_gnt` equals `ext_req` whenever `mem_lock` is low and is low while it is high. A granted external read returns data on `ext_rdata` in the next cycle.
- R10: With `done`, a legal bit-reverse or circular operation raises `upd_en`. `upd_circ` is high for circular, `upd_areg` carries bits [15:12] and `upd_off` carries the 10-bit offset. Base-plus-offset operations never raise `upd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| instr | input | 32 | Instruction word |
| base_addr | input | 32 | Base address register contents |
| ptr_ctl | input | 32 | Companion pointer register contents |
| swap_val | input | DW | Even register of the pair (value to store) |
| cmp_val | input | DW | Odd register of the pair (compare value) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unrecognised encoding, valid with done |
| swap_hit | output | 1 | Comparison matched, valid with done |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | DW | Old memory word |
| upd_en | output | 1 | Pointer update request |
| upd_circ | output | 1 | Update is circular (else bit-reverse) |
| upd_areg | output | 4 | Address register to update |
| upd_off | output | 10 | Offset field for the update |
| mem_lock | output | 1 | Memory held for the atomic window |
| ext_req | input | 1 | External requester access request |
| ext_we | input | 1 | External write enable |
| ext_addr | input | AW | External word address |
| ext_wdata | input | DW | External write data |
| ext_gnt | output | 1 | External access granted this cycle |
| ext_rdata | output | DW | External read data, cycle after grant |

## Verification
A legal operation has `busy` and `mem_lock` rise one cycle after `start` is sampled. `done`, `rd_data`, `swap_hit` and the update request follow on the third cycle after the start cycle. An illegal encoding finishes on the first cycle after it. External read data arrives one cycle after its grant. The bench reference model advances at each rising edge by the same counts. Inputs are driven just after the edge and every output is compared at the falling edge, so each result is checked in the exact cycle it is due. Memory contents after swaps and mismatches are read back through the external port, including a read that waits out an active lock.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CMP,
    ST_WRITE,
    ST_DONE
  } cas_state_t;

  typedef enum logic [1:0] {
    AM_NONE,
    AM_BASEOFF,
    AM_BITREV,
    AM_CIRC
  } amode_t;

  localparam logic [7:0] PRI_BASEOFF = 8'h49;
  localparam logic [7:0] PRI_PTRMOD  = 8'h69;
  localparam logic [5:0] SEC_BASEOFF = 6'h23;
  localparam logic [5:0] SEC_BITREV  = 6'h03;
  localparam logic [5:0] SEC_CIRC    = 6'h13;

  typedef struct packed {
    amode_t     mode;
    logic [9:0] off;
    logic [3:0] areg;
    logic [3:0] dreg;
  } cas_dec_t;

endpackage

// File: rtl/cas_decode.sv
module cas_decode
  import cas_pkg::*;
(
  input  logic [31:0] instr,
  output cas_dec_t    dec,
  output logic        legal
);
  logic [7:0] pri;
  logic [5:0] sec;

  always_comb begin
    pri      = instr[7:0];
    sec      = instr[27:22];
    dec.off  = {instr[31:28], instr[21:16]};
    dec.areg = instr[15:12];
    dec.dreg = instr[11:8];
    dec.mode = AM_NONE;
    if (pri == PRI_BASEOFF && sec == SEC_BASEOFF) dec.mode = AM_BASEOFF;
    else if (pri == PRI_PTRMOD && sec == SEC_BITREV) dec.mode = AM_BITREV;
    else if (pri == PRI_PTRMOD && sec == SEC_CIRC) dec.mode = AM_CIRC;
    legal = (dec.mode != AM_NONE);
  end
endmodule

// File: rtl/cas_agen.sv
module cas_agen
  import cas_pkg::*;
#(
  parameter int AW = 8
) (
  input  amode_t          mode,
  input  logic [9:0]      off,
  input  logic [31:0]     base_addr,
  input  logic [31:0]     ptr_ctl,
  output logic [AW-1:0]   word_idx
);
  localparam int LSB = 2;
  logic [31:0] byte_addr;

  always_comb begin
    if (mode == AM_BASEOFF)
      byte_addr = base_addr + {{22{off[9]}}, off};
    else
      byte_addr = base_addr + {16'b0, ptr_ctl[15:0]};
    word_idx = byte_addr[AW+LSB-1:LSB];
  end
endmodule

// File: rtl/cas_ram.sv
module cas_ram #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      dout <= mem[addr];
    end
  end
endmodule

// File: rtl/cas_arb.sv
module cas_arb #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          lock,
  input  logic          cas_en,
  input  logic          cas_we,
  input  logic [AW-1:0] cas_addr,
  input  logic [DW-1:0] cas_wdata,
  input  logic          ext_req,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic          ext_gnt,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  always_comb begin
    ext_gnt = ext_req && !lock;
    if (cas_en) begin
      ram_en    = 1'b1;
      ram_we    = cas_we;
      ram_addr  = cas_addr;
      ram_wdata = cas_wdata;
    end else begin
      ram_en    = ext_gnt;
      ram_we    = ext_gnt && ext_we;
      ram_addr  = ext_addr;
      ram_wdata = ext_wdata;
    end
  end
endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          legal,
  input  cas_dec_t      dec,
  input  logic [AW-1:0] word_idx,
  input  logic [DW-1:0] swap_val,
  input  logic [DW-1:0] cmp_val,
  input  logic [DW-1:0] ram_dout,
  output logic          busy,
  output logic          lock,
  output logic          cas_en,
  output logic          cas_we,
  output logic [AW-1:0] cas_addr,
  output logic [DW-1:0] cas_wdata,
  output logic          done,
  output logic          illegal,
  output logic          swap_hit,
  output logic          rd_we,
  output logic [3:0]    rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          upd_en,
  output logic          upd_circ,
  output logic [3:0]    upd_areg,
  output logic [9:0]    upd_off
);
  cas_state_t    state;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] swap_q, cmp_q, old_q;
  logic          hit_q;
  cas_dec_t      dec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ea_q     <= '0;
      swap_q   <= '0;
      cmp_q    <= '0;
      old_q    <= '0;
      hit_q    <= 1'b0;
      dec_q    <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      swap_hit <= 1'b0;
      rd_we    <= 1'b0;
      rd_idx   <= '0;
      rd_data  <= '0;
      upd_en   <= 1'b0;
      upd_circ <= 1'b0;
      upd_areg <= '0;
      upd_off  <= '0;
    end else begin
      done     <= 1'b0;
      illegal  <= 1'b0;
      swap_hit <= 1'b0;
      rd_we    <= 1'b0;
      upd_en   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ea_q   <= word_idx;
            swap_q <= swap_val;
            cmp_q  <= cmp_val;
            dec_q  <= dec;
            if (legal) begin
              state <= ST_READ;
            end else begin
              state   <= ST_DONE;
              done    <= 1'b1;
              illegal <= 1'b1;
              rd_idx  <= dec.dreg;
            end
          end
        end
        ST_READ: state <= ST_CMP;
        ST_CMP: begin
          old_q <= ram_dout;
          hit_q <= (ram_dout == cmp_q);
          state <= ST_WRITE;
        end
        ST_WRITE: begin
          state    <= ST_DONE;
          done     <= 1'b1;
          rd_we    <= 1'b1;
          rd_data  <= old_q;
          rd_idx   <= dec_q.dreg;
          swap_hit <= hit_q;
          upd_en   <= (dec_q.mode == AM_BITREV) || (dec_q.mode == AM_CIRC);
          upd_circ <= (dec_q.mode == AM_CIRC);
          upd_areg <= dec_q.areg;
          upd_off  <= dec_q.off;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    lock      = (state == ST_READ) || (state == ST_CMP) || (state == ST_WRITE);
    cas_en    = (state == ST_READ) || (state == ST_WRITE);
    cas_we    = (state == ST_WRITE);
    cas_addr  = ea_q;
    cas_wdata = hit_q ? swap_q : old_q;
  end
endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic [31:0]   base_addr,
  input  logic [31:0]   ptr_ctl,
  input  logic [DW-1:0] swap_val,
  input  logic [DW-1:0] cmp_val,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic          swap_hit,
  output logic          rd_we,
  output logic [3:0]    rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          upd_en,
  output logic          upd_circ,
  output logic [3:0]    upd_areg,
  output logic [9:0]    upd_off,
  output logic          mem_lock,
  input  logic          ext_req,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic          ext_gnt,
  output logic [DW-1:0] ext_rdata
);
  cas_dec_t      dec;
  logic          legal;
  logic [AW-1:0] word_idx;
  logic          cas_en, cas_we;
  logic [AW-1:0] cas_addr;
  logic [DW-1:0] cas_wdata;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_dout;

  cas_decode u_dec (
    .instr (instr),
    .dec   (dec),
    .legal (legal)
  );

  cas_agen #(.AW(AW)) u_agen (
    .mode      (dec.mode),
    .off       (dec.off),
    .base_addr (base_addr),
    .ptr_ctl   (ptr_ctl),
    .word_idx  (word_idx)
  );

  cas_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .legal     (legal),
    .dec       (dec),
    .word_idx  (word_idx),
    .swap_val  (swap_val),
    .cmp_val   (cmp_val),
    .ram_dout  (ram_dout),
    .busy      (busy),
    .lock      (mem_lock),
    .cas_en    (cas_en),
    .cas_we    (cas_we),
    .cas_addr  (cas_addr),
    .cas_wdata (cas_wdata),
    .done      (done),
    .illegal   (illegal),
    .swap_hit  (swap_hit),
    .rd_we     (rd_we),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .upd_en    (upd_en),
    .upd_circ  (upd_circ),
    .upd_areg  (upd_areg),
    .upd_off   (upd_off)
  );

  cas_arb #(.DW(DW), .AW(AW)) u_arb (
    .lock      (mem_lock),
    .cas_en    (cas_en),
    .cas_we    (cas_we),
    .cas_addr  (cas_addr),
    .cas_wdata (cas_wdata),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_gnt   (ext_gnt),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  cas_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .dout  (ram_dout)
  );

  assign ext_rdata = ram_dout;
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic illegal,
  input logic rd_we,
  input logic upd_en,
  input logic mem_lock,
  input logic ext_gnt
);
  // R9: external port refused during the atomic window
  a_r9_no_grant_when_locked: assert property (@(posedge clk) disable iff (rst)
    mem_lock |-> !ext_gnt);

  // R9: lock spans read, compare and write, then the done cycle follows
  a_r9_lock_window: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_lock) |=> mem_lock ##1 mem_lock ##1 (!mem_lock && done));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: locked operation implies busy
  a_r8_busy_when_locked: assert property (@(posedge clk) disable iff (rst)
    mem_lock |-> busy);

  // R7: register write only with a legal completion
  a_r7_rdwe_with_done: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> (done && !illegal));

  // R2: illegal completion follows no memory lock
  a_r2_illegal_no_access: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> !$past(mem_lock));

  // R10: pointer update request only with a legal completion
  a_r10_upd_with_done: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (done && rd_we));
endmodule

bind cas_unit cas_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal),
  .rd_we    (rd_we),
  .upd_en   (upd_en),
  .mem_lock (mem_lock),
  .ext_gnt  (ext_gnt)
);

// File: tb/cas_unit_bench.sv
module cas_unit_bench;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [31:0]   instr = '0, base_addr = '0, ptr_ctl = '0;
  logic [DW-1:0] swap_val = '0, cmp_val = '0;
  logic          busy, done, illegal, swap_hit, rd_we, upd_en, upd_circ, mem_lock;
  logic [3:0]    rd_idx, upd_areg;
  logic [DW-1:0] rd_data, ext_rdata;
  logic [9:0]    upd_off;
  logic          ext_req = 1'b0, ext_we = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [DW-1:0] ext_wdata = '0;
  logic          ext_gnt;

  always #4 clk = ~clk;

  cas_unit #(.DW(DW), .AW(AW)) u_cas_unit (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .base_addr(base_addr),
    .ptr_ctl(ptr_ctl), .swap_val(swap_val), .cmp_val(cmp_val), .busy(busy),
    .done(done), .illegal(illegal), .swap_hit(swap_hit), .rd_we(rd_we),
    .rd_idx(rd_idx), .rd_data(rd_data), .upd_en(upd_en), .upd_circ(upd_circ),
    .upd_areg(upd_areg), .upd_off(upd_off), .mem_lock(mem_lock),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_gnt(ext_gnt), .ext_rdata(ext_rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] pri, input logic [5:0] sec,
                                     input logic [9:0] off, input logic [3:0] b,
                                     input logic [3:0] a);
    return {off[9:6], sec, off[5:0], b, a, pri};
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 + i * 32'h0001_0103;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mem [NW];
  int          m_phase;
  int          m_mode;
  logic [AW-1:0] m_ea;
  logic [31:0] m_swap, m_cmp, m_old;
  bit          m_hit;
  logic [3:0]  m_ra, m_rb;
  logic [9:0]  m_off;
  bit          e_done, e_ill, e_rdwe, e_hit, e_upd, e_updc, e_extv;
  logic [3:0]  e_rdidx, e_upda;
  logic [9:0]  e_updo;
  logic [31:0] e_rddata, e_extrd;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; e_done = 0; e_ill = 0; e_rdwe = 0; e_hit = 0; e_upd = 0;
      e_extv = 0;
    end else begin
      bit lk;
      lk = (m_phase >= 1 && m_phase <= 3);
      e_done = 0; e_ill = 0; e_rdwe = 0; e_hit = 0; e_upd = 0; e_extv = 0;
      if (ext_req && !lk) begin
        e_extv  = !ext_we;
        e_extrd = m_mem[ext_addr];
        if (ext_we) m_mem[ext_addr] = ext_wdata;
      end
      case (m_phase)
        0: if (start) begin
          logic [31:0] ba;
          m_off = {instr[31:28], instr[21:16]};
          m_ra  = instr[11:8];
          m_rb  = instr[15:12];
          if (instr[7:0] == 8'h49 && instr[27:22] == 6'h23) m_mode = 1;
          else if (instr[7:0] == 8'h69 && instr[27:22] == 6'h03) m_mode = 2;
          else if (instr[7:0] == 8'h69 && instr[27:22] == 6'h13) m_mode = 3;
          else m_mode = 0;
          if (m_mode == 1) ba = base_addr + 32'(signed'(m_off));
          else ba = base_addr + {16'h0, ptr_ctl[15:0]};
          m_ea = ba[AW+1:2];
          m_swap = swap_val;
          m_cmp = cmp_val;
          if (m_mode == 0) begin
            m_phase = 4; e_done = 1; e_ill = 1; e_rdidx = m_ra;
          end else m_phase = 1;
        end
        1: begin m_old = m_mem[m_ea]; m_phase = 2; end
        2: begin m_hit = (m_old == m_cmp); m_phase = 3; end
        3: begin
          if (m_hit) m_mem[m_ea] = m_swap;
          e_done = 1; e_rdwe = 1; e_rddata = m_old; e_hit = m_hit; e_rdidx = m_ra;
          e_upd = (m_mode != 1); e_updc = (m_mode == 3); e_upda = m_rb; e_updo = m_off;
          m_phase = 4;
        end
        default: m_phase = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst) begin
      chk(!busy && !done && !illegal && !rd_we && !upd_en && !mem_lock, "R1 reset outputs",
          {26'h0, busy, done, illegal, rd_we, upd_en, mem_lock}, 32'h0);
    end else begin
      bit lk;
      lk = (m_phase >= 1 && m_phase <= 3);
      chk(busy == (m_phase != 0), "R8 busy", 32'(busy), 32'(m_phase != 0));
      chk(done == e_done, "R8 done timing", 32'(done), 32'(e_done));
      chk(mem_lock == lk, "R9 lock window", 32'(mem_lock), 32'(lk));
      chk(ext_gnt == (ext_req && !lk), "R9 ext grant", 32'(ext_gnt), 32'(ext_req && !lk));
      chk(illegal == e_ill, "R2 illegal flag", 32'(illegal), 32'(e_ill));
      chk(rd_we == e_rdwe, "R7 rd_we", 32'(rd_we), 32'(e_rdwe));
      if (e_done) chk(rd_idx == e_rdidx, "R7 rd_idx", 32'(rd_idx), 32'(e_rdidx));
      if (e_rdwe) begin
        chk(rd_data == e_rddata, "R7 old word", rd_data, e_rddata);
        chk(swap_hit == e_hit, "R5 R6 swap_hit", 32'(swap_hit), 32'(e_hit));
      end
      chk(upd_en == e_upd, "R10 upd_en", 32'(upd_en), 32'(e_upd));
      if (e_upd)
        chk({upd_circ, upd_areg, upd_off} == {e_updc, e_upda, e_updo}, "R10 upd fields",
            32'({upd_circ, upd_areg, upd_off}), 32'({e_updc, e_upda, e_updo}));
      if (e_extv) chk(ext_rdata == e_extrd, "R9 ext read data", ext_rdata, e_extrd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic ext_acc(input bit we, input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    ext_req = 1; ext_we = we; ext_addr = a; ext_wdata = d;
    forever begin
      @(negedge clk);
      if (ext_gnt) break;
    end
    @(posedge clk); #1;
    ext_req = 0; ext_we = 0;
  endtask

  task automatic readback(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    ext_acc(1'b0, a, '0);
    @(negedge clk);
    chk(ext_rdata == exp, tag, ext_rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] p,
                       input logic [31:0] sw, input logic [31:0] cm);
    @(posedge clk); #1;
    start = 1; instr = ins; base_addr = b; ptr_ctl = p; swap_val = sw; cmp_val = cm;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic cas_op(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] p,
                        input logic [31:0] sw, input logic [31:0] cm);
    pulse(ins, b, p, sw, cm);
    repeat (5) @(posedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int i = 0; i < NW; i++) ext_acc(1'b1, AW'(i), pat(i));

    // R3: base 0x40 + 0x20 -> word 24, match -> swap
    cas_op(mk(8'h49, 6'h23, 10'h020, 4'd3, 4'd2), 32'h40, 32'h0, 32'h1111_0001, pat(24));
    readback(8'd24, 32'h1111_0001, "R3 R5 swapped word");

    // R3: base 0x100 - 8 -> word 62, mismatch -> unchanged
    cas_op(mk(8'h49, 6'h23, 10'h3F8, 4'd1, 4'd4), 32'h100, 32'h0, 32'h2222_0002,
           pat(62) + 1);
    readback(8'd62, pat(62), "R3 R6 unchanged word");

    // R4: bit-reverse, base 0x200 + 0x10 -> word 132, match
    cas_op(mk(8'h69, 6'h03, 10'h000, 4'd6, 4'd8), 32'h200, 32'h1234_0010, 32'h3333_0003,
           pat(132));
    readback(8'd132, 32'h3333_0003, "R4 R5 bit-reverse swap");

    // R4: circular, base 0x300 + 0x8 -> word 194, mismatch then match
    cas_op(mk(8'h69, 6'h13, 10'h1F4, 4'd5, 4'd10), 32'h300, 32'h0040_0008, 32'h4444_0004,
           32'h0);
    readback(8'd194, pat(194), "R4 R6 circular mismatch");
    cas_op(mk(8'h69, 6'h13, 10'h204, 4'd7, 4'd12), 32'h300, 32'h0040_0008, 32'h5555_0005,
           pat(194));
    readback(8'd194, 32'h5555_0005, "R4 R5 circular swap");

    // R2: illegal pairs, no memory change
    cas_op(mk(8'h49, 6'h03, 10'h000, 4'd0, 4'd0), 32'h0, 32'h0, 32'hDEAD_0000, pat(0));
    cas_op(mk(8'h69, 6'h23, 10'h000, 4'd0, 4'd14), 32'h0, 32'h0, 32'hDEAD_0001, pat(0));
    cas_op(mk(8'h12, 6'h13, 10'h000, 4'd0, 4'd6), 32'h0, 32'h0, 32'hDEAD_0002, pat(0));
    readback(8'd0, pat(0), "R2 no access on illegal");

    // R8: start during busy is ignored
    pulse(mk(8'h49, 6'h23, 10'h004, 4'd2, 4'd2), 32'h0, 32'h0, 32'h6666_0006, pat(1));
    pulse(mk(8'h49, 6'h23, 10'h008, 4'd2, 4'd4), 32'h0, 32'h0, 32'h7777_0007, pat(2));
    repeat (5) @(posedge clk);
    readback(8'd1, 32'h6666_0006, "R8 first op done");
    readback(8'd2, pat(2), "R8 start while busy ignored");

    // R9: external read waits out the lock and sees the swapped value
    pulse(mk(8'h49, 6'h23, 10'h00C, 4'd2, 4'd0), 32'h0, 32'h0, 32'h8888_0008, pat(3));
    readback(8'd3, 32'h8888_0008, "R9 atomic read after lock");
    repeat (4) @(posedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule